// File: doc/BRIEF.md
# PCIe MSI Capture Controller

This block collects message-signalled interrupts for a PCIe root port. Software programs a 64-bit capture address, a 32-bit vector enable word and a 32-bit mask word through a 32-bit configuration register port. A separate inbound memory-write port carries writes arriving from downstream devices. A write of exactly four bytes whose address equals the programmed capture address counts as an interrupt message. Its data value names a vector, and the status bit of that vector is set when the vector is enabled.

A single level interrupt line tells the host that vectors are pending. A two-state machine drives the line. In `IRQ_IDLE` the line is low. The transition *raise* moves to `IRQ_RAISED` when some status bit is set and that bit is not masked. In `IRQ_RAISED` the line is high, and the transition *drop* returns to `IRQ_IDLE` only when the whole status word is zero. Masking a vector therefore stops a new assertion but does not withdraw one already made. Software acknowledges vectors by writing ones to the status register.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset the capture address, enable, mask and status registers all read 0, `irq` is low and the state machine is in `IRQ_IDLE`.
- R2: Offset 0x820 holds bits 31:0 of the capture address and offset 0x824 holds bits 63:32. A write to either offset replaces only that half, leaves the other half unchanged, and reads back the value written.
- R3: An inbound write with `in_len` = 4, `in_addr` equal to the capture address and a non-zero enable register captures data value n (n < 32) into status bit n when enable bit n is 1. The status bit is set at the clock edge that samples the write, and at most one bit is set by each write.
- R4: `irq` rises one cycle after status AND NOT mask becomes non-zero (transition *raise*).
- R5: While the enable register is 0, every inbound write is ignored. An inbound write whose address differs from the capture address in any bit is also ignored.
- R6: An inbound write with `in_len` other than 4 is ignored.
- R7: An inbound data value of 32 or more selects no vector and leaves status unchanged.
- R8: Writing to status (offset 0x830) clears each bit written as 1 and leaves bits written as 0. `irq` stays high while any status bit is set, masked or not, and falls one cycle after status becomes zero (transition *drop*).
- R9: When a capture and a status clear hit the same bit in the same cycle, the bit ends up set.
- R10: Enable (offset 0x828) and mask (offset 0x82C) are full 32-bit read/write registers. Any other offset reads 0, and writing to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration register byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` (combinational) |
| in_valid | input | 1 | Inbound memory write present this cycle |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| in_len | input | 3 | Inbound write length in bytes |
| irq | output | 1 | Level interrupt, high while vectors are pending |

## Verification
The assertions check on every cycle how the interrupt line relates to the status and mask words. They check that *raise* follows an unmasked pending vector, that the line holds while status is non-zero and that *drop* happens only after status is zero. They also check that a capture sets at most one new status bit and never a disabled one, that a short or missing write sets nothing, and that each address-half write leaves the other half alone. Only the bench's scenarios can show that each individual vector maps to the right status bit, that address mismatches and out-of-range data are rejected, and that a capture beats a clear of the same bit in the same cycle.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
    localparam int OFF_W = 12;
    localparam logic [OFF_W-1:0] OFF_ADDR_LO = 12'h820;
    localparam logic [OFF_W-1:0] OFF_ADDR_HI = 12'h824;
    localparam logic [OFF_W-1:0] OFF_ENABLE  = 12'h828;
    localparam logic [OFF_W-1:0] OFF_MASK    = 12'h82C;
    localparam logic [OFF_W-1:0] OFF_STATUS  = 12'h830;
    localparam int LEN_W     = 3;
    localparam int MSG_BYTES = 4;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OFF_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] msi_addr,
    output logic [DATA_W-1:0] vec_enable,
    output logic [DATA_W-1:0] vec_mask
);
    localparam int HALVES = ADDR_W / DATA_W;

    logic [DATA_W-1:0] addr_half [HALVES];

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam logic [OFF_W-1:0] HOFF = OFF_ADDR_LO + OFF_W'(4 * h);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_half[h] <= '0;
            end else if (cfg_we && cfg_addr == HOFF) begin
                addr_half[h] <= cfg_wdata;
            end
        end
        assign msi_addr[h*DATA_W +: DATA_W] = addr_half[h];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_enable <= '0;
            vec_mask   <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == OFF_ENABLE) vec_enable <= cfg_wdata;
            if (cfg_addr == OFF_MASK)   vec_mask   <= cfg_wdata;
        end
    end
endmodule

// File: rtl/msi_cap_match.sv
module msi_cap_match
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DATA_W  = 32,
    parameter int NUM_VEC = 32
) (
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [LEN_W-1:0]   in_len,
    input  logic [ADDR_W-1:0]  msi_addr,
    input  logic [DATA_W-1:0]  vec_enable,
    output logic [NUM_VEC-1:0] set_vec
);
    localparam int VEC_W = $clog2(NUM_VEC);

    logic window_open;
    logic hit;
    logic in_range;

    assign window_open = |vec_enable;
    assign hit      = in_valid && (in_len == LEN_W'(MSG_BYTES))
                      && (in_addr == msi_addr) && window_open;
    assign in_range = in_data < DATA_W'(NUM_VEC);

    always_comb begin
        set_vec = '0;
        if (hit && in_range) begin
            set_vec = (NUM_VEC'(1) << in_data[VEC_W-1:0]) & vec_enable[NUM_VEC-1:0];
        end
    end
endmodule

// File: rtl/msi_cap_status.sv
module msi_cap_status
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] clr_bits,
    input  logic [NUM_VEC-1:0] set_vec,
    input  logic [NUM_VEC-1:0] vec_mask,
    output logic [NUM_VEC-1:0] vec_status,
    output logic               irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_status <= '0;
        else        vec_status <= (vec_status & ~clr_bits) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (|(vec_status & ~vec_mask)) state_d = IRQ_RAISED;
            IRQ_RAISED: if (vec_status == '0)          state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DATA_W  = 32,
    parameter int NUM_VEC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [11:0]       cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [2:0]        in_len,
    output logic              irq
);
    logic [ADDR_W-1:0]  msi_addr;
    logic [DATA_W-1:0]  vec_enable;
    logic [DATA_W-1:0]  vec_mask;
    logic [NUM_VEC-1:0] vec_status;
    logic [NUM_VEC-1:0] set_vec;
    logic [NUM_VEC-1:0] clr_bits;

    msi_cap_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .msi_addr   (msi_addr),
        .vec_enable (vec_enable),
        .vec_mask   (vec_mask)
    );

    msi_cap_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)) u_match (
        .in_valid   (in_valid),
        .in_addr    (in_addr),
        .in_data    (in_data),
        .in_len     (in_len),
        .msi_addr   (msi_addr),
        .vec_enable (vec_enable),
        .set_vec    (set_vec)
    );

    assign clr_bits = (cfg_we && cfg_addr == OFF_STATUS) ? cfg_wdata[NUM_VEC-1:0] : '0;

    msi_cap_status #(.NUM_VEC(NUM_VEC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_bits   (clr_bits),
        .set_vec    (set_vec),
        .vec_mask   (vec_mask[NUM_VEC-1:0]),
        .vec_status (vec_status),
        .irq        (irq)
    );

    always_comb begin
        case (cfg_addr)
            OFF_ADDR_LO: cfg_rdata = msi_addr[DATA_W-1:0];
            OFF_ADDR_HI: cfg_rdata = msi_addr[ADDR_W-1:DATA_W];
            OFF_ENABLE:  cfg_rdata = vec_enable;
            OFF_MASK:    cfg_rdata = vec_mask;
            OFF_STATUS:  cfg_rdata = DATA_W'(vec_status);
            default:     cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msi_capture_ctrl_chk.sv
module msi_capture_ctrl_chk
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DATA_W  = 32,
    parameter int NUM_VEC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [11:0]        cfg_addr,
    input logic [DATA_W-1:0]  cfg_wdata,
    input logic               in_valid,
    input logic [2:0]         in_len,
    input logic               irq,
    input logic [ADDR_W-1:0]  msi_addr,
    input logic [DATA_W-1:0]  vec_enable,
    input logic [DATA_W-1:0]  vec_mask,
    input logic [NUM_VEC-1:0] vec_status
);
    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == OFF_ADDR_LO) |=>
        (msi_addr[ADDR_W-1:DATA_W] == $past(msi_addr[ADDR_W-1:DATA_W])
         && msi_addr[DATA_W-1:0] == $past(cfg_wdata))); // R2

    AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == OFF_ADDR_HI) |=>
        (msi_addr[DATA_W-1:0] == $past(msi_addr[DATA_W-1:0])
         && msi_addr[ADDR_W-1:DATA_W] == $past(cfg_wdata))); // R2

    AST_NEW_BITS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((vec_status & ~$past(vec_status) & ~$past(vec_enable[NUM_VEC-1:0])) == '0)); // R3

    AST_ONE_NEW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(vec_status & ~$past(vec_status)) <= 1)); // R3

    AST_BAD_LEN_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_len == LEN_W'(MSG_BYTES)) |=> ((vec_status & ~$past(vec_status)) == '0)); // R6

    AST_WINDOW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_enable == '0) |=> ((vec_status & ~$past(vec_status)) == '0)); // R5

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && |(vec_status & ~vec_mask[NUM_VEC-1:0])) |=> irq); // R4

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(vec_status & ~vec_mask[NUM_VEC-1:0]))); // R4

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && vec_status != '0) |=> irq); // R8

    AST_IRQ_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(vec_status == '0)); // R8
endmodule

bind msi_capture_ctrl msi_capture_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)
) u_chk (.*);

// File: tb/tb_msi_capture_ctrl.sv
module tb_msi_capture_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic [2:0]  in_len = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [63:0] CAP_ADDR = 64'h0000_00AB_1234_5678;

    always #2 clk = ~clk;

    msi_capture_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .in_data(in_data), .in_len(in_len), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic cfg_wr(logic [11:0] off, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(logic [11:0] off, output logic [31:0] d);
        cfg_addr = off;
        #0.5;
        d = cfg_rdata;
    endtask

    task automatic send(logic [63:0] a, logic [31:0] d, logic [2:0] len);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d; in_len = len;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R1 reset state
        cfg_rd(12'h820, v); chk("R1 addr lo", v, 0);
        cfg_rd(12'h824, v); chk("R1 addr hi", v, 0);
        cfg_rd(12'h828, v); chk("R1 enable", v, 0);
        cfg_rd(12'h82C, v); chk("R1 mask", v, 0);
        cfg_rd(12'h830, v); chk("R1 status", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R10 enable/mask full width, unmapped offsets
        cfg_wr(12'h828, 32'hA5A5_5A5A);
        cfg_wr(12'h82C, 32'h0F0F_F0F0);
        cfg_rd(12'h828, v); chk("R10 enable", v, 32'hA5A5_5A5A);
        cfg_rd(12'h82C, v); chk("R10 mask", v, 32'h0F0F_F0F0);
        for (int o = 12'h800; o < 12'h840; o += 4) begin
            if (o < 12'h820 || o > 12'h830) begin
                cfg_wr(12'(o), 32'hFFFF_FFFF);
                cfg_rd(12'(o), v); chk("R10 unmapped read", v, 0);
            end
        end
        cfg_rd(12'h828, v); chk("R10 enable untouched", v, 32'hA5A5_5A5A);
        cfg_rd(12'h82C, v); chk("R10 mask untouched", v, 32'h0F0F_F0F0);
        cfg_rd(12'h820, v); chk("R10 addr lo untouched", v, 0);

        // R2 address halves
        cfg_wr(12'h820, CAP_ADDR[31:0]);
        cfg_rd(12'h824, v); chk("R2 hi kept", v, 0);
        cfg_wr(12'h824, CAP_ADDR[63:32]);
        cfg_rd(12'h820, v); chk("R2 lo kept", v, CAP_ADDR[31:0]);
        cfg_rd(12'h824, v); chk("R2 hi", v, CAP_ADDR[63:32]);

        // R3/R4/R8 sweep every vector
        cfg_wr(12'h828, 32'hFFFF_FFFF);
        cfg_wr(12'h82C, 32'h0);
        for (int n = 0; n < 32; n++) begin
            send(CAP_ADDR, 32'(n), 3'd4);
            cfg_rd(12'h830, v); chk("R3 vector capture", v, 32'h1 << n);
            idle();
            chk("R4 irq raised", {31'b0, irq}, 1);
            cfg_wr(12'h830, 32'h1 << n);
            cfg_rd(12'h830, v); chk("R8 cleared", v, 0);
            idle();
            chk("R8 irq dropped", {31'b0, irq}, 0);
        end

        // R3 partial enable, accumulating
        cfg_wr(12'h828, 32'h0000_FFFF);
        acc = 0;
        for (int n = 0; n < 32; n++) begin
            send(CAP_ADDR, 32'(n), 3'd4);
            if (n < 16) acc |= 32'h1 << n;
            cfg_rd(12'h830, v); chk("R3 enable gated", v, acc);
        end
        cfg_wr(12'h830, 32'h0000_00FF);
        cfg_rd(12'h830, v); chk("R8 partial clear", v, 32'h0000_FF00);
        idle();
        chk("R8 irq held", {31'b0, irq}, 1);
        cfg_wr(12'h830, 32'hFFFF_FFFF);
        idle();
        chk("R8 irq low", {31'b0, irq}, 0);
        cfg_wr(12'h828, 32'hFFFF_FFFF);

        // R7 out-of-range data
        for (int d = 32; d < 80; d++) begin
            send(CAP_ADDR, 32'(d), 3'd4);
        end
        send(CAP_ADDR, 32'hFFFF_FFFF, 3'd4);
        send(CAP_ADDR, 32'h0000_0100, 3'd4);
        cfg_rd(12'h830, v); chk("R7 no vector", v, 0);

        // R6 wrong lengths
        for (int l = 0; l < 8; l++) begin
            if (l != 4) begin
                send(CAP_ADDR, 32'd9, 3'(l));
                cfg_rd(12'h830, v); chk("R6 length ignored", v, 0);
            end
        end

        // R5 address mismatch in each bit
        for (int b = 0; b < 64; b++) begin
            send(CAP_ADDR ^ (64'h1 << b), 32'd2, 3'd4);
        end
        cfg_rd(12'h830, v); chk("R5 mismatch ignored", v, 0);
        idle();
        chk("R5 irq low", {31'b0, irq}, 0);

        // R5 window closed
        cfg_wr(12'h828, 32'h0);
        for (int n = 0; n < 32; n++) send(CAP_ADDR, 32'(n), 3'd4);
        cfg_rd(12'h830, v); chk("R5 window closed", v, 0);
        cfg_wr(12'h828, 32'hFFFF_FFFF);

        // R4/R8 masking
        cfg_wr(12'h82C, 32'h0000_0060);
        send(CAP_ADDR, 32'd5, 3'd4);
        idle(); idle();
        chk("R4 masked no irq", {31'b0, irq}, 0);
        send(CAP_ADDR, 32'd7, 3'd4);
        idle();
        chk("R4 unmasked irq", {31'b0, irq}, 1);
        cfg_wr(12'h82C, 32'h0000_00E0);
        cfg_wr(12'h830, 32'h0000_0080);
        idle(); idle();
        chk("R8 sticky while masked pending", {31'b0, irq}, 1);
        cfg_wr(12'h830, 32'h0000_0020);
        idle();
        chk("R8 drop after empty", {31'b0, irq}, 0);
        cfg_wr(12'h82C, 32'h0);

        // R9 capture wins over same-cycle clear
        send(CAP_ADDR, 32'd3, 3'd4);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 12'h830; cfg_wdata = 32'h0000_0008;
        in_valid = 1'b1; in_addr = CAP_ADDR; in_data = 32'd3; in_len = 3'd4;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        cfg_rd(12'h830, v); chk("R9 capture wins", v, 32'h0000_0008);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 12'h830; cfg_wdata = 32'h0000_0008;
        in_valid = 1'b1; in_addr = CAP_ADDR; in_data = 32'd4; in_len = 3'd4;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        cfg_rd(12'h830, v); chk("R9 other bit cleared", v, 32'h0000_0010);

        // R1 reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cfg_rd(12'h830, v); chk("R1 status after reset", v, 0);
        cfg_rd(12'h824, v); chk("R1 addr after reset", v, 0);
        chk("R1 irq after reset", {31'b0, irq}, 0);

        report();
    end
endmodule